// File: doc/BRIEF.md
# Dual-Wiper Serial Command Slave

This block is a two-wire serial bus slave that owns two 5-bit wiper position registers, one for a left channel and one for a right channel. It oversamples the bus clock and data lines with the system clock, finds START and STOP conditions, and answers only to its own address. Two strap inputs set the low address bits, so four copies can share one bus. A host can load either register or both, read both back, or enter a streaming step mode. In that mode each further bus clock pulse nudges the selected wiper up or down by one tap.

The data line is open-drain. The block never drives it high: `sda_oe` high means "pull the line low". The system clock must run at least 16 times faster than the bus clock. Both registers come out of reset at tap 0, which is the mute position. Each register has a one-cycle strobe that marks every update. A zero-crossing enable flag taken from the last accepted command is also provided.

Top module: `dual_wiper_slave`

## Requirements
- R1: After synchronous reset, both taps are 0, `sda_oe` is low and `zd_flag` is low.
- R2: The first byte after START is received MSB first and compared as `0101`, `0`, strap[1], strap[0], followed by a read/write bit (1 = read). On a match the slave pulls SDA low for the ninth clock. On a mismatch it gives no acknowledge and ignores all traffic until the next START.
- R3: In a write, the second byte is a command. Bits [7:4] are the opcode: `1010` means load, `0010` means step. Bit 3 must be 0. Bit 2 is the zero-crossing enable. Bit 1 selects the right register and bit 0 selects the left register. Any other opcode, bit 3 set, or neither channel selected gives no acknowledge, goes idle and changes no register.
- R4: After a load command with one channel selected, one data byte is accepted and acknowledged. Its bits [4:0] go into the selected register, and bits [7:5] are ignored.
- R5: After a load command with both channels selected, two data bytes are accepted: the first goes to the left register and the second to the right. Any further data byte in that transaction gets no acknowledge.
- R6: With the read/write bit set, no command byte follows. The slave sends {000, left tap} and then {000, right tap}, both MSB first. If the master does not acknowledge a byte, the slave releases SDA and goes idle.
- R7: In step mode, each SCL high phase with SDA high moves every selected register up one tap, and each with SDA low moves it down one. The value saturates at 31 and at 0.
- R8: A step takes effect when SCL falls. A high phase that ends in STOP produces no step.
- R9: `zd_flag` takes bit 2 of each accepted command and keeps its value through rejected commands and data traffic.
- R10: START (SDA falling while SCL is high) restarts address reception from any state, including in the middle of a transaction. STOP (SDA rising while SCL is high) returns the slave to idle, and an idle slave never pulls SDA low.
- R11: A register changes only in a clock cycle in which its update strobe is high. Each load or step gives exactly one strobe pulse, one cycle long.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, at least 16x the bus clock |
| rst | input | 1 | Synchronous active-high reset |
| addr_strap | input | 2 | Low two address bits |
| scl_in | input | 1 | Bus clock line, asynchronous |
| sda_in | input | 1 | Bus data line as seen on the wire, asynchronous |
| sda_oe | output | 1 | High to pull the data line low |
| left_tap | output | 5 | Left wiper position |
| right_tap | output | 5 | Right wiper position |
| zd_flag | output | 1 | Zero-crossing enable from the last accepted command |
| left_upd | output | 1 | One-cycle pulse when the left register is written or stepped |
| right_upd | output | 1 | One-cycle pulse when the right register is written or stepped |

## Verification
A wrong bit counter or a wrong state after a byte shows up within one bus bit time. It appears as a missing or misplaced acknowledge on the ninth clock, or as read data shifted by a bit. A wrong channel-select latch or a byte-count fault shows up when the transaction ends, as a tap that differs from the model. The bench compares the taps with the model on every clock while the bus is idle. A step counter that wraps, or a step committed on the rising edge, shows in the tap right after the pulse that reaches saturation or right after the STOP that ends step mode.

// File: rtl/dwp_pkg.sv
package dwp_pkg;
    localparam int BYTE_W = 8;
    localparam logic [3:0] DEV_ID   = 4'b0101;
    localparam logic [3:0] OP_LOAD  = 4'b1010;
    localparam logic [3:0] OP_STEP  = 4'b0010;
    localparam int NUM_CH = 2;

    typedef enum logic [2:0] {
        S_IDLE, S_ADDR, S_CMD, S_WDATA, S_ACK, S_READ, S_RACK, S_STEP
    } st_t;

    typedef struct packed {
        logic [3:0] op;
        logic       rsvd;
        logic       zd;
        logic       rt;
        logic       lt;
    } cmd_t;

    function automatic logic cmd_valid(cmd_t c);
        return ((c.op == OP_LOAD) || (c.op == OP_STEP)) && !c.rsvd && (c.rt || c.lt);
    endfunction
endpackage

// File: rtl/dwp_line_sync.sv
module dwp_line_sync #(
    parameter int   STAGES  = 2,
    parameter logic RST_VAL = 1'b1
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic level,
    output logic rise,
    output logic fall
);
    logic stg [0:STAGES];
    logic prev;

    assign stg[0] = d;

    for (genvar g = 0; g < STAGES; g++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst) stg[g+1] <= RST_VAL;
            else     stg[g+1] <= stg[g];
        end
    end

    always_ff @(posedge clk) begin
        if (rst) prev <= RST_VAL;
        else     prev <= stg[STAGES];
    end

    assign level = stg[STAGES];
    assign rise  = stg[STAGES] & ~prev;
    assign fall  = ~stg[STAGES] & prev;
endmodule

// File: rtl/dwp_tap_reg.sv
module dwp_tap_reg #(
    parameter int W = 5
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         load,
    input  logic [W-1:0] load_val,
    input  logic         step,
    input  logic         up,
    output logic [W-1:0] tap,
    output logic         upd
);
    localparam logic [W-1:0] TOP = '1;
    logic [W-1:0] stepped;

    always_comb begin
        if (up) stepped = (tap == TOP)  ? tap : tap + 1'b1;
        else    stepped = (tap == '0)   ? tap : tap - 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            tap <= '0;
            upd <= 1'b0;
        end else begin
            upd <= load | step;
            if (load)      tap <= load_val;
            else if (step) tap <= stepped;
        end
    end
endmodule

// File: rtl/dual_wiper_slave.sv
module dual_wiper_slave
    import dwp_pkg::*;
#(
    parameter int TAP_W       = 5,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [1:0]       addr_strap,
    input  logic             scl_in,
    input  logic             sda_in,
    output logic             sda_oe,
    output logic [TAP_W-1:0] left_tap,
    output logic [TAP_W-1:0] right_tap,
    output logic             zd_flag,
    output logic             left_upd,
    output logic             right_upd
);
    localparam int CNT_W = $clog2(BYTE_W + 1);

    logic scl_s, scl_rise, scl_fall;
    logic sda_s, sda_rise, sda_fall;
    logic start_ev, stop_ev;

    dwp_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_scl_sync (
        .clk(clk), .rst(rst), .d(scl_in), .level(scl_s), .rise(scl_rise), .fall(scl_fall));
    dwp_line_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_sda_sync (
        .clk(clk), .rst(rst), .d(sda_in), .level(sda_s), .rise(sda_rise), .fall(sda_fall));

    assign start_ev = sda_fall & scl_s;
    assign stop_ev  = sda_rise & scl_s;

    st_t               st, nxt;
    logic [CNT_W-1:0]  bitcnt;
    logic [BYTE_W-1:0] sh_in, sh_out;
    logic [NUM_CH-1:0] ch_sel;
    logic [1:0]        byte_cnt;
    logic              rd_right, mack, pend, pend_up, oe, zd_q;
    logic [NUM_CH-1:0] ld_sel, step_sel, upd;
    logic [TAP_W-1:0]  ld_val;
    logic              step_up;
    logic [TAP_W-1:0]  taps [NUM_CH];

    cmd_t              cmd_in;
    logic              addr_hit, both, wr_room;
    logic [NUM_CH-1:0] wr_target;
    logic [BYTE_W-1:0] lbyte, rbyte;

    assign cmd_in    = cmd_t'(sh_in);
    assign addr_hit  = (sh_in[BYTE_W-1:1] == {DEV_ID, 1'b0, addr_strap});
    assign both      = &ch_sel;
    assign wr_room   = both ? (byte_cnt < 2'd2) : (byte_cnt == 2'd0);
    assign wr_target = both ? ((byte_cnt == 2'd0) ? 2'b01 : 2'b10) : ch_sel;
    assign lbyte     = BYTE_W'(taps[0]);
    assign rbyte     = BYTE_W'(taps[1]);

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= S_IDLE;  nxt <= S_IDLE;  bitcnt <= '0;
            sh_in <= '0;   sh_out <= '0;   ch_sel <= '0;  byte_cnt <= '0;
            rd_right <= 1'b0; mack <= 1'b0; pend <= 1'b0; pend_up <= 1'b0;
            oe <= 1'b0;    zd_q <= 1'b0;
            ld_sel <= '0;  ld_val <= '0;   step_sel <= '0; step_up <= 1'b0;
        end else begin
            ld_sel   <= '0;
            step_sel <= '0;
            if (start_ev) begin
                st <= S_ADDR; bitcnt <= '0; oe <= 1'b0; pend <= 1'b0;
            end else if (stop_ev) begin
                st <= S_IDLE; oe <= 1'b0; pend <= 1'b0;
            end else begin
                case (st)
                    S_ADDR, S_CMD, S_WDATA: begin
                        if (scl_rise) begin
                            sh_in  <= {sh_in[BYTE_W-2:0], sda_s};
                            bitcnt <= bitcnt + 1'b1;
                        end else if (scl_fall && bitcnt == CNT_W'(BYTE_W)) begin
                            st <= S_IDLE;
                            if (st == S_ADDR) begin
                                if (addr_hit) begin
                                    oe <= 1'b1; st <= S_ACK;
                                    nxt <= sh_in[0] ? S_READ : S_CMD;
                                end
                            end else if (st == S_CMD) begin
                                if (cmd_valid(cmd_in)) begin
                                    oe <= 1'b1; st <= S_ACK;
                                    ch_sel <= {cmd_in.rt, cmd_in.lt};
                                    zd_q <= cmd_in.zd;
                                    byte_cnt <= '0;
                                    nxt <= (cmd_in.op == OP_STEP) ? S_STEP : S_WDATA;
                                end
                            end else if (wr_room) begin
                                oe <= 1'b1; st <= S_ACK; nxt <= S_WDATA;
                                ld_sel <= wr_target;
                                ld_val <= sh_in[TAP_W-1:0];
                                byte_cnt <= byte_cnt + 1'b1;
                            end
                        end
                    end
                    S_ACK: if (scl_fall) begin
                        oe <= 1'b0; bitcnt <= '0; st <= nxt; pend <= 1'b0;
                        if (nxt == S_READ) begin
                            sh_out <= lbyte; oe <= ~lbyte[BYTE_W-1]; rd_right <= 1'b0;
                        end
                    end
                    S_READ: if (scl_fall) begin
                        if (bitcnt == CNT_W'(BYTE_W - 1)) begin
                            oe <= 1'b0; bitcnt <= '0; st <= S_RACK;
                        end else begin
                            bitcnt <= bitcnt + 1'b1;
                            sh_out <= {sh_out[BYTE_W-2:0], 1'b0};
                            oe     <= ~sh_out[BYTE_W-2];
                        end
                    end
                    S_RACK: begin
                        if (scl_rise) mack <= ~sda_s;
                        else if (scl_fall) begin
                            if (mack && !rd_right) begin
                                sh_out <= rbyte; oe <= ~rbyte[BYTE_W-1];
                                rd_right <= 1'b1; st <= S_READ;
                            end else st <= S_IDLE;
                        end
                    end
                    S_STEP: begin
                        if (scl_rise) begin
                            pend <= 1'b1; pend_up <= sda_s;
                        end else if (scl_fall && pend) begin
                            pend <= 1'b0; step_sel <= ch_sel; step_up <= pend_up;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        dwp_tap_reg #(.W(TAP_W)) u_tap (
            .clk(clk), .rst(rst), .load(ld_sel[c]), .load_val(ld_val),
            .step(step_sel[c]), .up(step_up), .tap(taps[c]), .upd(upd[c]));
    end

    logic in_step, in_idle;
    assign in_step   = (st == S_STEP);
    assign in_idle   = (st == S_IDLE);
    assign sda_oe    = oe;
    assign zd_flag   = zd_q;
    assign left_tap  = taps[0];
    assign right_tap = taps[1];
    assign left_upd  = upd[0];
    assign right_upd = upd[1];
endmodule

// File: rtl/dual_wiper_slave_chk.sv
module dual_wiper_slave_chk #(
    parameter int TAP_W = 5
) (
    input logic             clk,
    input logic             rst,
    input logic             scl_s,
    input logic             in_step,
    input logic             in_idle,
    input logic             sda_oe,
    input logic [TAP_W-1:0] left_tap,
    input logic [TAP_W-1:0] right_tap,
    input logic             zd_flag,
    input logic             left_upd,
    input logic             right_upd
);
    p_reset_mute_r1: assert property (@(posedge clk)
        rst |=> (left_tap == '0 && right_tap == '0 && !sda_oe && !zd_flag));

    p_ack_on_low_r2: assert property (@(posedge clk) disable iff (rst)
        $rose(sda_oe) |-> !scl_s);

    p_step_unit_r7: assert property (@(posedge clk) disable iff (rst)
        (in_step && left_tap != $past(left_tap)) |->
            (left_tap == $past(left_tap) + 1'b1 || left_tap == $past(left_tap) - 1'b1));

    p_idle_release_r10: assert property (@(posedge clk) disable iff (rst)
        in_idle |-> !sda_oe);

    p_left_change_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        (left_tap != $past(left_tap)) |-> left_upd);

    p_right_change_strobe_r11: assert property (@(posedge clk) disable iff (rst)
        (right_tap != $past(right_tap)) |-> right_upd);

    p_strobe_single_r11: assert property (@(posedge clk) disable iff (rst)
        (left_upd || right_upd) |=> !(left_upd && $past(left_upd)) && !(right_upd && $past(right_upd)));
endmodule

bind dual_wiper_slave dual_wiper_slave_chk #(.TAP_W(TAP_W)) u_chk (
    .clk(clk), .rst(rst), .scl_s(scl_s), .in_step(in_step), .in_idle(in_idle),
    .sda_oe(sda_oe), .left_tap(left_tap), .right_tap(right_tap), .zd_flag(zd_flag),
    .left_upd(left_upd), .right_upd(right_upd));

// File: tb/dual_wiper_slave_tb.sv
module dual_wiper_slave_tb;
    localparam int Q = 20;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic [1:0] strap = 2'b10;
    logic scl_m = 1'b1, sda_m = 1'b1;
    logic sda_oe, zd_flag, left_upd, right_upd;
    logic [4:0] left_tap, right_tap;
    wire sda_line = sda_m & ~sda_oe;

    always #2.5 clk = ~clk;

    dual_wiper_slave u_dut (
        .clk(clk), .rst(rst), .addr_strap(strap), .scl_in(scl_m), .sda_in(sda_line),
        .sda_oe(sda_oe), .left_tap(left_tap), .right_tap(right_tap), .zd_flag(zd_flag),
        .left_upd(left_upd), .right_upd(right_upd));

    int checks = 0, errors = 0;
    int exp_l = 0, exp_r = 0;
    int nl = 0, nr = 0;
    bit track = 1'b0;

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    always @(posedge clk) if (!rst) begin
        if (left_upd)  nl++;
        if (right_upd) nr++;
    end

    // Reference model comparison on every clock while the bus is idle
    always @(negedge clk) if (track) begin
        checks++;
        if (left_tap !== 5'(exp_l) || right_tap !== 5'(exp_r)) begin
            errors++;
            $display("FAIL R11 model L=%0d R=%0d expected L=%0d R=%0d",
                     left_tap, right_tap, exp_l, exp_r);
        end
    end

    function automatic int sat(input int v);
        return (v > 31) ? 31 : ((v < 0) ? 0 : v);
    endfunction

    task automatic hq(); repeat (Q) @(negedge clk); endtask
    task automatic bstart(); track = 0; sda_m = 1; hq(); scl_m = 1; hq(); sda_m = 0; hq(); scl_m = 0; hq(); endtask
    task automatic bstop();  sda_m = 0; hq(); scl_m = 1; hq(); sda_m = 1; hq(); hq(); track = 1; endtask
    task automatic bbit(input logic b); sda_m = b; hq(); scl_m = 1; hq(); hq(); scl_m = 0; hq(); endtask
    task automatic getbit(output logic b); sda_m = 1; hq(); scl_m = 1; hq(); b = sda_line; hq(); scl_m = 0; hq(); endtask

    task automatic wbyte(input logic [7:0] v, output bit ack);
        logic b;
        for (int i = 7; i >= 0; i--) bbit(v[i]);
        getbit(b);
        ack = !b;
    endtask

    task automatic rbyte(output logic [7:0] v, input bit give_ack);
        logic b;
        for (int i = 7; i >= 0; i--) begin getbit(b); v[i] = b; end
        bbit(give_ack ? 1'b0 : 1'b1);
    endtask

    task automatic summary();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        checks++; errors++;
        $display("FAIL R10 watchdog actual=0 expected=1");
        summary();
    end

    initial begin
        bit a;
        logic [7:0] d;
        int l0, r0;
        repeat (5) @(negedge clk);
        rst = 0;
        repeat (3) @(negedge clk);
        // R1 reset state
        chk(left_tap == 0 && right_tap == 0, "R1 taps", left_tap + right_tap, 0);
        chk(!sda_oe && !zd_flag, "R1 oe/zd", sda_oe + zd_flag, 0);
        track = 1;

        // Single write left = 17, zd = 1; address 0x54 = 0101_0_10_0
        l0 = nl;
        bstart();
        wbyte(8'h54, a); chk(a, "R2 address ack", a, 1);
        wbyte(8'hA5, a); chk(a, "R3 load cmd ack", a, 1);
        wbyte(8'h11, a); chk(a, "R4 data ack", a, 1);
        exp_l = 17;
        bstop();
        chk(left_tap == 17 && right_tap == 0, "R4 single load", left_tap, 17);
        chk(zd_flag == 1, "R9 zd latched", zd_flag, 1);
        chk(nl - l0 == 1, "R11 one strobe per load", nl - l0, 1);

        // Wrong strap: 0x52 -> no ack, following bytes ignored
        bstart();
        wbyte(8'h52, a); chk(!a, "R2 mismatch nack", a, 0);
        wbyte(8'hA6, a); chk(!a, "R2 ignored cmd", a, 0);
        wbyte(8'h05, a); chk(!a, "R2 ignored data", a, 0);
        bstop();
        chk(left_tap == 17 && right_tap == 0, "R2 no change", right_tap, 0);

        // Bad opcode, reserved bit, no select
        bstart();
        wbyte(8'h54, a);
        wbyte(8'hF1, a); chk(!a, "R3 bad opcode nack", a, 0);
        wbyte(8'h09, a); chk(!a, "R3 data after reject", a, 0);
        bstop();
        bstart();
        wbyte(8'h54, a);
        wbyte(8'hA8 | 8'h01, a); chk(!a, "R3 reserved bit nack", a, 0);
        bstop();
        bstart();
        wbyte(8'h54, a);
        wbyte(8'hA0, a); chk(!a, "R3 no select nack", a, 0);
        bstop();
        chk(zd_flag == 1, "R9 zd held on reject", zd_flag, 1);
        chk(left_tap == 17, "R3 no change", left_tap, 17);

        // Dual load: left 3, right 29, extra byte refused
        bstart();
        wbyte(8'h54, a);
        wbyte(8'hA3, a); chk(a, "R5 both cmd ack", a, 1);
        wbyte(8'h03, a); chk(a, "R5 first data ack", a, 1);
        wbyte(8'h1D, a); chk(a, "R5 second data ack", a, 1);
        wbyte(8'h07, a); chk(!a, "R5 third data nack", a, 0);
        exp_l = 3; exp_r = 29;
        bstop();
        chk(left_tap == 3 && right_tap == 29, "R5 dual load", right_tap, 29);
        chk(zd_flag == 0, "R9 zd cleared", zd_flag, 1'b0);

        // Read both
        bstart();
        wbyte(8'h55, a); chk(a, "R6 read address ack", a, 1);
        rbyte(d, 1); chk(d == 8'h03, "R6 left byte", d, 3);
        rbyte(d, 0); chk(d == 8'h1D, "R6 right byte", d, 29);
        chk(!sda_oe, "R6 released after nack", sda_oe, 0);
        bstop();
        // Early NACK after left byte
        bstart();
        wbyte(8'h55, a);
        rbyte(d, 0); chk(d == 8'h03, "R6 left only", d, 3);
        hq();
        chk(!sda_oe, "R6 idle after early nack", sda_oe, 0);
        bstop();

        // Step right: up x3 saturates at 31, down x2
        bstart();
        wbyte(8'h54, a);
        wbyte(8'h22, a); chk(a, "R7 step cmd ack", a, 1);
        for (int i = 0; i < 3; i++) begin
            bbit(1'b1); exp_r = sat(exp_r + 1);
            chk(right_tap == 5'(exp_r), "R7 step up", right_tap, exp_r);
        end
        chk(right_tap == 31, "R7 saturate high", right_tap, 31);
        for (int i = 0; i < 2; i++) begin
            bbit(1'b0); exp_r = sat(exp_r - 1);
            chk(right_tap == 5'(exp_r), "R7 step down", right_tap, exp_r);
        end
        chk(left_tap == 3, "R7 unselected held", left_tap, 3);
        bstop();
        chk(right_tap == 29, "R8 stop high phase no step", right_tap, 29);

        // Step both down x4: left saturates at 0
        bstart();
        wbyte(8'h54, a);
        wbyte(8'h23, a);
        for (int i = 0; i < 4; i++) begin
            bbit(1'b0); exp_l = sat(exp_l - 1); exp_r = sat(exp_r - 1);
        end
        chk(left_tap == 0, "R7 saturate low", left_tap, 0);
        chk(right_tap == 25, "R7 both channels", right_tap, 25);
        bstop();

        // Repeated START mid-transaction
        r0 = nr;
        bstart();
        wbyte(8'h54, a);
        wbyte(8'hA1, a);
        bstart();
        wbyte(8'h54, a); chk(a, "R10 restart address ack", a, 1);
        wbyte(8'hA2, a);
        wbyte(8'hEB, a); chk(a, "R10 data after restart", a, 1);
        exp_r = 11;
        bstop();
        chk(right_tap == 11 && left_tap == 0, "R4 upper bits ignored", right_tap, 11);
        chk(nr - r0 == 1, "R11 right strobe count", nr - r0, 1);
        chk(!sda_oe, "R10 idle release", sda_oe, 0);

        repeat (10) @(negedge clk);
        summary();
    end
endmodule